// File: doc/BRIEF.md
# UART Interrupt Controller and Receive Holding Status

This block holds the interrupt and receive-side status logic of a memory-mapped serial port. Four interrupt sources each own one sticky state bit, one enable bit and one level output. Software clears state bits by writing ones to the state register. It can force state bits by writing ones to a test register, which always reads as zero. Transmit-side logic and the deserializer raise state bits with single-cycle pulses.

The receive side has a one-byte holding register. The deserializer offers a byte with a strobe. The block takes the byte only while receive is enabled and the holder is empty, and `rx_ready` shows that condition. A read of the data register hands the byte to software. When receive is enabled, the read also frees the holder and sets the empty and idle flags again. The status register packs three transmit flags, which are sampled from inputs, together with the three receive flags.

Top module: `uart_irq_rxstat`

## Requirements
- R1: After reset, the status register (word 4) reads 0x3C. Every other register and any unmapped word reads 0. All interrupt outputs are low and `rx_ready` is low.
- R2: The source bit order is: 0 transmit watermark, 1 receive watermark, 2 transmit empty, 3 receive overflow. Each output is high exactly when its state bit and its enable bit are both set. A write to the enable register (word 1) replaces the whole enable value, and the outputs follow from the next cycle.
- R3: A write to the state register (word 0) clears every state bit written as 1 and leaves the other state bits unchanged.
- R4: A write to the test register (word 2) ORs the written bits into the state. A read of word 2 returns 0.
- R5: The pulses `tx_wmark_pulse`, `tx_empty_pulse` and `rx_ovf_pulse` set state bits 0, 2 and 3. A set from a pulse in the same cycle as a write-1-to-clear of that bit wins.
- R6: `rx_ready` equals receive-enable (control register word 3, bit 1) AND NOT rx-full. A strobe on `rx_valid` while `rx_ready` is low changes neither the stored byte nor the flags.
- R7: An accepted byte is stored. It sets rx-full, clears rx-idle and rx-empty, raises the receive level to one and sets state bit 1.
- R8: A read of the data register (word 5) returns the stored byte. When receive is enabled and the level is nonzero, the read lowers the level. Rx-full then clears, and rx-idle and rx-empty set once the level reaches zero. With receive disabled, the read has no side effect.
- R9: The status layout is: bit0 tx-full, bit1 rx-full, bit2 tx-empty, bit3 tx-idle, bit4 rx-idle, bit5 rx-empty. The tx bits follow `tx_full_in`, `tx_empty_in` and `tx_idle_in` one cycle later.
- R10: Writes to the status register and to the data register change nothing.
- R11: The control register (word 3) stores and reads back all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (the data-register read has side effects) |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current state |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Holder can accept a byte |
| tx_wmark_pulse | input | 1 | Transmit watermark event |
| tx_empty_pulse | input | 1 | Transmit empty event |
| rx_ovf_pulse | input | 1 | Receive overflow event |
| tx_full_in | input | 1 | Transmit FIFO full flag |
| tx_empty_in | input | 1 | Transmit FIFO empty flag |
| tx_idle_in | input | 1 | Transmitter idle flag |
| irq_tx_wmark | output | 1 | Interrupt line, source 0 |
| irq_rx_wmark | output | 1 | Interrupt line, source 1 |
| irq_tx_empty | output | 1 | Interrupt line, source 2 |
| irq_rx_ovf | output | 1 | Interrupt line, source 3 |

## Verification
The hardest situation to reach from the ports is a byte that is held while receive is disabled. In that state a data-register read must return the byte without freeing the holder. The stimulus first accepts a byte, then clears the enable, and reads twice. Only after re-enabling does a read free the holder. A second hard case is a clear colliding with a hardware set on the same bit. The bench issues the state-register write and the pulse on the same clock edge.

// File: rtl/uirs_pkg.sv
package uirs_pkg;
  localparam int NSRC = 4;
  localparam int AW   = 4;

  localparam int SRC_TX_WM    = 0;
  localparam int SRC_RX_WM    = 1;
  localparam int SRC_TX_EMPTY = 2;
  localparam int SRC_RX_OVF   = 3;

  localparam logic [AW-1:0] ADR_STATE  = 4'd0;
  localparam logic [AW-1:0] ADR_ENABLE = 4'd1;
  localparam logic [AW-1:0] ADR_TEST   = 4'd2;
  localparam logic [AW-1:0] ADR_CTRL   = 4'd3;
  localparam logic [AW-1:0] ADR_STATUS = 4'd4;
  localparam logic [AW-1:0] ADR_DATA   = 4'd5;

  localparam int CTRL_RXEN_BIT = 1;

  // next interrupt state: clears first, then every set source wins
  function automatic logic [NSRC-1:0] irq_next(
    input logic [NSRC-1:0] cur,
    input logic [NSRC-1:0] clr,
    input logic [NSRC-1:0] tst,
    input logic [NSRC-1:0] hw
  );
    return (cur & ~clr) | tst | hw;
  endfunction

  function automatic logic [5:0] status_pack(
    input logic tx_full, input logic rx_full, input logic tx_empty,
    input logic tx_idle, input logic rx_idle, input logic rx_empty
  );
    return {rx_empty, rx_idle, tx_idle, tx_empty, rx_full, tx_full};
  endfunction
endpackage

// File: rtl/uirs_irq_bank.sv
module uirs_irq_bank
  import uirs_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic         clr_we,
  input  logic         tst_we,
  input  logic [N-1:0] wbits,
  input  logic [N-1:0] hw_set,
  output logic [N-1:0] state_q,
  output logic [N-1:0] enable_q,
  output logic [N-1:0] irq
);
  logic [N-1:0] clr_bits;
  logic [N-1:0] tst_bits;

  assign clr_bits = clr_we ? wbits : '0;
  assign tst_bits = tst_we ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= '0;
      enable_q <= '0;
    end else begin
      state_q <= irq_next(state_q, clr_bits, tst_bits, hw_set);
      if (en_we) enable_q <= wbits;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    assign irq[i] = state_q[i] & enable_q[i];
  end
endmodule

// File: rtl/uirs_rx_hold.sv
module uirs_rx_hold #(
  parameter int BYTE_W = 8,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_pop,
  output logic              rx_ready,
  output logic              accept,
  output logic [BYTE_W-1:0] byte_q,
  output logic              full_q,
  output logic              empty_q,
  output logic              idle_q
);
  localparam logic [LVL_W-1:0] ONE = LVL_W'(1);

  logic [LVL_W-1:0] level_q;
  logic             pop_ok;

  assign rx_ready = rx_en & ~full_q;
  assign accept   = rx_valid & rx_ready;
  assign pop_ok   = rd_pop & rx_en & (level_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      byte_q  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      idle_q  <= 1'b1;
    end else if (accept) begin
      byte_q  <= rx_byte;
      level_q <= level_q + ONE;
      full_q  <= 1'b1;
      empty_q <= 1'b0;
      idle_q  <= 1'b0;
    end else if (pop_ok) begin
      level_q <= level_q - ONE;
      full_q  <= 1'b0;
      if (level_q == ONE) begin
        empty_q <= 1'b1;
        idle_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_irq_rxstat.sv
module uart_irq_rxstat
  import uirs_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LVL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_ready,
  input  logic              tx_wmark_pulse,
  input  logic              tx_empty_pulse,
  input  logic              rx_ovf_pulse,
  input  logic              tx_full_in,
  input  logic              tx_empty_in,
  input  logic              tx_idle_in,
  output logic              irq_tx_wmark,
  output logic              irq_rx_wmark,
  output logic              irq_tx_empty,
  output logic              irq_rx_ovf
);
  logic [31:0]       ctrl_q;
  logic [2:0]        txf_q;
  logic [NSRC-1:0]   int_state;
  logic [NSRC-1:0]   int_enable;
  logic [NSRC-1:0]   irq_vec;
  logic [NSRC-1:0]   hw_set;
  logic              rx_accept;
  logic              rx_en;
  logic [BYTE_W-1:0] rx_byte_q;
  logic              rx_full;
  logic              rx_empty;
  logic              rx_idle;
  logic              wr_state;
  logic              wr_enable;
  logic              wr_test;
  logic              rd_data;
  logic [5:0]        status_bits;

  assign wr_state  = reg_wr & (reg_addr == ADR_STATE);
  assign wr_enable = reg_wr & (reg_addr == ADR_ENABLE);
  assign wr_test   = reg_wr & (reg_addr == ADR_TEST);
  assign rd_data   = reg_rd & (reg_addr == ADR_DATA);
  assign rx_en     = ctrl_q[CTRL_RXEN_BIT];

  always_comb begin
    hw_set               = '0;
    hw_set[SRC_TX_WM]    = tx_wmark_pulse;
    hw_set[SRC_RX_WM]    = rx_accept;
    hw_set[SRC_TX_EMPTY] = tx_empty_pulse;
    hw_set[SRC_RX_OVF]   = rx_ovf_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      txf_q  <= 3'b110;  // {idle, empty, full}
    end else begin
      if (reg_wr && reg_addr == ADR_CTRL) ctrl_q <= reg_wdata;
      txf_q <= {tx_idle_in, tx_empty_in, tx_full_in};
    end
  end

  uirs_irq_bank #(.N(NSRC)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (wr_enable),
    .clr_we   (wr_state),
    .tst_we   (wr_test),
    .wbits    (reg_wdata[NSRC-1:0]),
    .hw_set   (hw_set),
    .state_q  (int_state),
    .enable_q (int_enable),
    .irq      (irq_vec)
  );

  uirs_rx_hold #(.BYTE_W(BYTE_W), .LVL_W(LVL_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rd_pop   (rd_data),
    .rx_ready (rx_ready),
    .accept   (rx_accept),
    .byte_q   (rx_byte_q),
    .full_q   (rx_full),
    .empty_q  (rx_empty),
    .idle_q   (rx_idle)
  );

  assign status_bits = status_pack(txf_q[0], rx_full, txf_q[1], txf_q[2],
                                   rx_idle, rx_empty);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_STATE:  reg_rdata[NSRC-1:0]   = int_state;
      ADR_ENABLE: reg_rdata[NSRC-1:0]   = int_enable;
      ADR_CTRL:   reg_rdata             = ctrl_q;
      ADR_STATUS: reg_rdata[5:0]        = status_bits;
      ADR_DATA:   reg_rdata[BYTE_W-1:0] = rx_byte_q;
      default:    reg_rdata             = '0;
    endcase
  end

  assign irq_tx_wmark = irq_vec[SRC_TX_WM];
  assign irq_rx_wmark = irq_vec[SRC_RX_WM];
  assign irq_tx_empty = irq_vec[SRC_TX_EMPTY];
  assign irq_rx_ovf   = irq_vec[SRC_RX_OVF];
endmodule

// File: rtl/uirs_chk.sv
module uirs_chk
  import uirs_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [AW-1:0]     reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [NSRC-1:0]   irq_vec,
  input logic [NSRC-1:0]   int_state,
  input logic [NSRC-1:0]   hw_set,
  input logic              rx_accept,
  input logic              rx_ready,
  input logic              rx_en,
  input logic              rx_full,
  input logic              rx_empty,
  input logic              rx_idle,
  input logic [BYTE_W-1:0] rx_byte_q
);
  // R2
  enable_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_ENABLE) |=> ((irq_vec & ~$past(reg_wdata[NSRC-1:0])) == '0));

  // R3
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_STATE && hw_set == '0) |=> ((int_state & $past(reg_wdata[NSRC-1:0])) == '0));

  // R4
  test_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_TEST) |=> ((int_state & $past(reg_wdata[NSRC-1:0])) == $past(reg_wdata[NSRC-1:0])));

  // R7
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> (rx_full && !rx_empty && !rx_idle && !rx_ready && int_state[SRC_RX_WM]));

  // R8
  rx_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_DATA && rx_en && rx_full) |=> (!rx_full && rx_empty && rx_idle));

  // R6
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !(reg_rd && reg_addr == ADR_DATA)) |=> ($stable(rx_byte_q) && rx_full));

  // R10
  data_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_DATA && !rx_accept) |=> $stable(rx_byte_q));
endmodule

bind uart_irq_rxstat uirs_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_vec   (irq_vec),
  .int_state (int_state),
  .hw_set    (hw_set),
  .rx_accept (rx_accept),
  .rx_ready  (rx_ready),
  .rx_en     (rx_en),
  .rx_full   (rx_full),
  .rx_empty  (rx_empty),
  .rx_idle   (rx_idle),
  .rx_byte_q (rx_byte_q)
);

// File: tb/sim_uart_irq_rxstat.sv
module sim_uart_irq_rxstat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready;
  logic        tx_wmark_pulse = 1'b0;
  logic        tx_empty_pulse = 1'b0;
  logic        rx_ovf_pulse = 1'b0;
  logic        tx_full_in = 1'b0;
  logic        tx_empty_in = 1'b1;
  logic        tx_idle_in = 1'b1;
  logic        irq_tx_wmark, irq_rx_wmark, irq_tx_empty, irq_rx_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uart_irq_rxstat u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_wmark_pulse(tx_wmark_pulse), .tx_empty_pulse(tx_empty_pulse),
    .rx_ovf_pulse(rx_ovf_pulse), .tx_full_in(tx_full_in),
    .tx_empty_in(tx_empty_in), .tx_idle_in(tx_idle_in),
    .irq_tx_wmark(irq_tx_wmark), .irq_rx_wmark(irq_rx_wmark),
    .irq_tx_empty(irq_tx_empty), .irq_rx_ovf(irq_rx_ovf)
  );

  // register words
  localparam logic [3:0] W_ST = 4'd0, W_EN = 4'd1, W_TS = 4'd2, W_CT = 4'd3,
                         W_SS = 4'd4, W_DT = 4'd5;
  // vector: op(0 write, 1 read-compare, 2 irq-compare), word, data, expected
  localparam int NV = 18;
  localparam logic [71:0] VEC [NV] = '{
    {4'd0, W_EN, 32'h0000000F, 32'h0},        // R2
    {4'd1, W_ST, 32'h0, 32'h0},               // R2
    {4'd0, W_TS, 32'h00000005, 32'h0},        // R4
    {4'd1, W_ST, 32'h0, 32'h5},               // R4
    {4'd2, W_ST, 32'h0, 32'h5},               // R2
    {4'd0, W_ST, 32'h00000001, 32'h0},        // R3
    {4'd1, W_ST, 32'h0, 32'h4},               // R3
    {4'd1, W_TS, 32'h0, 32'h0},               // R4
    {4'd0, W_EN, 32'h0, 32'h0},               // R2
    {4'd2, W_ST, 32'h0, 32'h0},               // R2
    {4'd0, W_EN, 32'h00000004, 32'h0},        // R2
    {4'd2, W_ST, 32'h0, 32'h4},               // R2
    {4'd1, W_EN, 32'h0, 32'h4},               // R2
    {4'd0, W_ST, 32'hFFFFFFFF, 32'h0},        // R3
    {4'd1, W_ST, 32'h0, 32'h0},               // R3
    {4'd0, W_CT, 32'hA5C30000, 32'h0},        // R11
    {4'd1, W_CT, 32'h0, 32'hA5C30000},        // R11
    {4'd1, W_SS, 32'h0, 32'h3C}               // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #5 chk(req, reg_rdata, exp);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic irqs(input string req, input logic [3:0] exp);
    @(negedge clk); #1;
    chk(req, {28'h0, irq_rx_ovf, irq_tx_empty, irq_rx_wmark, irq_tx_wmark}, {28'h0, exp});
  endtask

  task automatic rxb(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd("R1", 4'(a), (a == 4) ? 32'h3C : 32'h0);
    irqs("R1", 4'h0);
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      v = VEC[i];
      case (v[71:68])
        4'd0: wr(v[67:64], v[63:32]);
        4'd1: rd("R2/R3/R4/R9/R11 vector", v[67:64], v[31:0]);
        default: irqs("R2 vector", v[3:0]);
      endcase
    end

    // R6: receive disabled -> byte ignored
    wr(W_CT, 32'h0);
    rxb(8'hA5);
    rd("R6", W_SS, 32'h3C);
    rd("R6", W_ST, 32'h0);
    rd("R6", W_DT, 32'h0);
    // R6/R7: enable and accept
    wr(W_CT, 32'h2);
    @(negedge clk); #1 chk("R6 ready", {31'h0, rx_ready}, 32'h1);
    rxb(8'h5A);
    @(negedge clk); #1 chk("R7 ready low", {31'h0, rx_ready}, 32'h0);
    rd("R7", W_SS, 32'h0E);
    rd("R7", W_ST, 32'h2);
    rxb(8'h11);  // full: ignored
    // R8 hold while disabled
    wr(W_CT, 32'h0);
    rd("R8", W_DT, 32'h5A);
    rd("R8", W_SS, 32'h0E);
    wr(W_CT, 32'h2);
    // R10 writes ignored
    wr(W_DT, 32'hFF);
    wr(W_SS, 32'h0);
    rd("R10", W_SS, 32'h0E);
    rd("R8", W_DT, 32'h5A);
    rd("R8", W_SS, 32'h3C);
    @(negedge clk); #1 chk("R8 ready", {31'h0, rx_ready}, 32'h1);
    rd("R8", W_DT, 32'h5A);
    rd("R8", W_SS, 32'h3C);

    // R5 pulses and set-wins
    wr(W_ST, 32'hF);
    @(negedge clk);
    tx_wmark_pulse = 1'b1; rx_ovf_pulse = 1'b1;
    @(posedge clk); #1;
    tx_wmark_pulse = 1'b0; rx_ovf_pulse = 1'b0;
    rd("R5", W_ST, 32'h9);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = W_ST; reg_wdata = 32'h4; tx_empty_pulse = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; tx_empty_pulse = 1'b0;
    rd("R5", W_ST, 32'hD);
    wr(W_EN, 32'hF);
    irqs("R5", 4'hD);

    // R9 tx flags
    tx_full_in = 1'b1; tx_empty_in = 1'b0; tx_idle_in = 1'b0;
    @(negedge clk);
    rd("R9", W_SS, 32'h31);

    finish_run();
  end
endmodule